// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of several localities owns a shared command interface at any moment. Each locality has a one-byte access register in its own 4 KB window of a simple register port. Through that register a locality asks for the interface, sees whether it holds it, learns that another locality is queued behind it, and hands the interface back. The block also drives the index of the owning locality and a one-cycle event whenever ownership moves, for the interrupt logic.

Nothing in the access registers means anything until the device has finished initialising. A sticky valid flag is set by an external init-done input. Until then every access register reads zero and every write to one is dropped. When the interface is free, the highest-numbered locality that is waiting wins on the following clock.

Top module: `loc_arbiter`

## Requirements
- R1: After reset no locality owns the interface. `active_any`, `loc_change` and `reg_rvalid` are 0, and `reg_rdata` is 0x00.
- R2: Bit 7 of every mapped access register reads 0 until `init_done` has been seen high on a clock edge, and 1 from then on. Before that edge every access register reads 0x00 and every write to one has no effect.
- R3: The locality index is `reg_addr[14:12]` and the register offset is `reg_addr[11:0]`. The access register sits at offset 0x000. A read of any other offset, or of a locality index of 5 or more, returns 0x00. A write there has no effect.
- R4: Writing a byte with bit 1 set to a locality's access register records a request for that locality. If the interface is free, it is granted on the next clock edge to the highest-numbered locality with a recorded request.
- R5: Bit 5 reads 1 only in the owner's access register. `active_loc` gives the owner's number and `active_any` is 1 while some locality owns the interface.
- R6: Bit 2 reads 1 in the owner's access register while at least one other locality has a request recorded. It reads 0 in every other access register.
- R7: Writing a byte with bit 5 set to the owner's access register frees the interface on that edge and clears the owner's request. The next grant follows on the next edge. Writing bit 5 from a locality that is not the owner has no effect.
- R8: A request written by the locality that already owns the interface is ignored. After that locality releases, it is not granted again unless it writes a new request.
- R9: `loc_change` is high for exactly the one cycle after each edge on which the owner changes, including a change to no owner.
- R10: Register bits other than 7, 5, 2 and 1 read 0. Writing 1 to bits 0, 2, 3, 4, 6 or 7 changes nothing.
- R11: A read strobed on one edge presents its byte on `reg_rdata`, with `reg_rvalid` high, for the following cycle. The byte reflects the state just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Device initialisation finished; sets the valid flag |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 15 | Byte address: locality in [14:12], offset in [11:0] |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| active_loc | output | 3 | Number of the owning locality (0 when none) |
| active_any | output | 1 | Some locality owns the interface |
| loc_change | output | 1 | One-cycle pulse after ownership moves |

## Verification
On every cycle, the assertions check that at most one locality holds the interface and that nothing is owned before the valid flag rises. They also check that a free interface with a waiting request is granted on the next edge, that an owner stays put until it writes a release, that the owner's request stays recorded, and that a read strobe is answered one cycle later. Some behaviour can only be shown by the bench's scenarios. These include which locality wins when several wait, the exact byte each register returns, that a foreign release or an undefined bit is ignored, that an owner's repeated request does not bring the interface back to it, and the timing of the change event across a release followed by a re-grant.

// File: rtl/loc_arb_pkg.sv
`timescale 1ns/1ps
package loc_arb_pkg;
  localparam int REG_W     = 8;
  localparam int B_VALID   = 7;
  localparam int B_ACTIVE  = 5;
  localparam int B_PENDING = 2;
  localparam int B_REQ     = 1;
endpackage

// File: rtl/loc_wr_decode.sv
`timescale 1ns/1ps
module loc_wr_decode
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int OFS_W   = 12,
  parameter int SEL_W   = 3
) (
  input  logic                   we,
  input  logic                   valid,
  input  logic [OFS_W+SEL_W-1:0] addr,
  input  logic [REG_W-1:0]       wdata,
  output logic [NUM_LOC-1:0]     req_set,
  output logic [NUM_LOC-1:0]     rel_wr
);
  logic [SEL_W-1:0] sel;
  logic             base_hit;

  assign sel      = addr[OFS_W +: SEL_W];
  assign base_hit = we && valid && (addr[OFS_W-1:0] == '0);

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    logic hit_i;
    assign hit_i      = base_hit && (sel == SEL_W'(i));
    assign req_set[i] = hit_i && wdata[B_REQ];
    assign rel_wr[i]  = hit_i && wdata[B_ACTIVE];
  end
endmodule

// File: rtl/loc_grant_ctrl.sv
`timescale 1ns/1ps
module loc_grant_ctrl #(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LOC-1:0] req_set,
  input  logic [NUM_LOC-1:0] rel_wr,
  output logic [NUM_LOC-1:0] own_q,
  output logic [NUM_LOC-1:0] req_q,
  output logic               evt_q
);
  logic [NUM_LOC-1:0] own_d, req_d, pick;
  logic               rel_hit;

  // highest-numbered waiting locality wins
  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_LOC; i++)
      if (req_q[i]) pick = NUM_LOC'(1) << i;
  end

  assign rel_hit = |(rel_wr & own_q);

  always_comb begin
    req_d = (req_q | (req_set & ~own_q)) & ~(rel_wr & own_q);
    if (rel_hit)
      own_d = '0;
    else if (own_q == '0)
      own_d = pick;
    else
      own_d = own_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q <= '0;
      req_q <= '0;
      evt_q <= 1'b0;
    end else begin
      own_q <= own_d;
      req_q <= req_d;
      evt_q <= (own_d != own_q);
    end
  end

  // R4: never more than one owner
  a_r4_single_owner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(own_q));
  // R4: free interface with a waiting request is granted next edge
  a_r4_grant_next: assert property (@(posedge clk) disable iff (rst)
    (own_q == '0 && req_q != '0) |=> (own_q != '0));
  // R7: owner holds until its own release write
  a_r7_hold_owner: assert property (@(posedge clk) disable iff (rst)
    (own_q != '0 && (rel_wr & own_q) == '0) |=> $stable(own_q));
  // R8: owner's request remains recorded while it owns
  a_r8_owner_req: assert property (@(posedge clk) disable iff (rst)
    (own_q & ~req_q) == '0);
endmodule

// File: rtl/loc_read_port.sv
`timescale 1ns/1ps
module loc_read_port
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int OFS_W   = 12,
  parameter int SEL_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   re,
  input  logic [OFS_W+SEL_W-1:0] addr,
  input  logic                   valid,
  input  logic [NUM_LOC-1:0]     own,
  input  logic [NUM_LOC-1:0]     req,
  output logic [REG_W-1:0]       rdata,
  output logic                   rvalid
);
  logic [SEL_W-1:0]  sel;
  logic              ofs_hit;
  logic              others_wait;
  logic [REG_W-1:0]  byte_v [NUM_LOC];
  logic [REG_W-1:0]  rdata_d;

  assign sel         = addr[OFS_W +: SEL_W];
  assign ofs_hit     = (addr[OFS_W-1:0] == '0);
  assign others_wait = |(req & ~own);

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_byte
    always_comb begin
      byte_v[i]            = '0;
      byte_v[i][B_VALID]   = valid;
      byte_v[i][B_ACTIVE]  = valid && own[i];
      byte_v[i][B_PENDING] = valid && own[i] && others_wait;
    end
  end

  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NUM_LOC; i++)
      if (ofs_hit && sel == SEL_W'(i)) rdata_d = byte_v[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= re ? rdata_d : '0;
      rvalid <= re;
    end
  end

  // R11: every read strobe answered one cycle later
  a_r11_read_latency: assert property (@(posedge clk) disable iff (rst)
    re |=> rvalid);
  // R3: off-map offsets read as zero
  a_r3_offmap_zero: assert property (@(posedge clk) disable iff (rst)
    (re && !ofs_hit) |=> (rdata == '0));
endmodule

// File: rtl/loc_arbiter.sv
`timescale 1ns/1ps
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int OFS_W   = 12,
  parameter int SEL_W   = 3,
  localparam int LOC_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   init_done,
  input  logic                   reg_we,
  input  logic                   reg_re,
  input  logic [OFS_W+SEL_W-1:0] reg_addr,
  input  logic [REG_W-1:0]       reg_wdata,
  output logic [REG_W-1:0]       reg_rdata,
  output logic                   reg_rvalid,
  output logic [LOC_W-1:0]       active_loc,
  output logic                   active_any,
  output logic                   loc_change
);
  logic               valid_q;
  logic [NUM_LOC-1:0] req_set, rel_wr, own_q, req_q;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= valid_q | init_done;
  end

  loc_wr_decode #(.NUM_LOC(NUM_LOC), .OFS_W(OFS_W), .SEL_W(SEL_W)) u_dec (
    .we(reg_we), .valid(valid_q), .addr(reg_addr), .wdata(reg_wdata),
    .req_set(req_set), .rel_wr(rel_wr)
  );

  loc_grant_ctrl #(.NUM_LOC(NUM_LOC)) u_grant (
    .clk(clk), .rst(rst), .req_set(req_set), .rel_wr(rel_wr),
    .own_q(own_q), .req_q(req_q), .evt_q(loc_change)
  );

  loc_read_port #(.NUM_LOC(NUM_LOC), .OFS_W(OFS_W), .SEL_W(SEL_W)) u_rd (
    .clk(clk), .rst(rst), .re(reg_re), .addr(reg_addr), .valid(valid_q),
    .own(own_q), .req(req_q), .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

  always_comb begin
    active_loc = '0;
    for (int i = 0; i < NUM_LOC; i++)
      if (own_q[i]) active_loc = LOC_W'(i);
  end
  assign active_any = |own_q;

  // R2: nothing is owned or waiting before the device is valid
  a_r2_idle_until_valid: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> (!active_any && req_q == '0));
  // R2: valid flag never drops once set
  a_r2_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> valid_q);
endmodule

// File: tb/sim_loc_arbiter.sv
`timescale 1ns/1ps
module sim_loc_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_done = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [14:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        reg_rvalid;
  logic [2:0]  active_loc;
  logic        active_any, loc_change;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  loc_arbiter u0 (
    .clk(clk), .rst(rst), .init_done(init_done), .reg_we(reg_we),
    .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .active_loc(active_loc),
    .active_any(active_any), .loc_change(loc_change)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // write; returns 1 ns after the edge that took it
  task automatic wr(input int loc, input int ofs, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 15'((loc << 12) | ofs); reg_wdata = d;
    @(posedge clk); #0.5;
    reg_we = 1'b0; #0.5;
  endtask

  // read driver: pushes the expected byte for the monitor
  task automatic rd(input int loc, input int ofs, input logic [7:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    reg_re = 1'b1; reg_addr = 15'((loc << 12) | ofs);
    @(posedge clk); #1;
    reg_re = 1'b0;
  endtask

  // monitor: pops and compares as read data appears
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: unexpected read data 0x%0h expected none", reg_rdata);
      end else begin
        chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk("R1 active_any", active_any, 0);
    chk("R1 loc_change", loc_change, 0);
    chk("R1 rvalid", reg_rvalid, 0);
    chk("R1 rdata", reg_rdata, 0);
    @(negedge clk); rst = 1'b0;

    rd(0, 0, 8'h00, "R2 invalid read");
    wr(3, 0, 8'h02); step(); step();
    chk("R2 write ignored before valid", active_any, 0);

    @(negedge clk); init_done = 1'b1;
    @(negedge clk); init_done = 1'b0;
    rd(0, 0, 8'h80, "R2 valid set");
    rd(5, 0, 8'h00, "R3 locality 5");
    rd(0, 4, 8'h00, "R3 other offset");
    wr(1, 8, 8'h02); step();
    chk("R3 off-map write ignored", active_any, 0);

    wr(2, 0, 8'h02);
    chk("R4 not yet granted", active_any, 0);
    step();
    chk("R4 grant loc2", active_loc, 2);
    chk("R9 event on grant", loc_change, 1);
    step();
    chk("R9 event one cycle", loc_change, 0);

    rd(2, 0, 8'hA0, "R5 owner alone");
    wr(0, 0, 8'h02); wr(4, 0, 8'h02); wr(1, 0, 8'h02); step();
    rd(2, 0, 8'hA4, "R6 owner sees waiters");
    rd(4, 0, 8'h80, "R6 waiter no pending");
    wr(4, 0, 8'h20); step();
    chk("R7 foreign release ignored", active_loc, 2);
    rd(2, 0, 8'hA4, "R7 owner unchanged");

    wr(2, 0, 8'h20);
    chk("R7 freed at release", active_any, 0);
    chk("R9 event on release", loc_change, 1);
    step();
    chk("R4 highest waiter loc4", active_loc, 4);
    chk("R9 event on regrant", loc_change, 1);
    step();
    rd(4, 0, 8'hA4, "R5 new owner");

    wr(4, 0, 8'h02); step();
    wr(4, 0, 8'h20); step();
    chk("R8 owner request ignored", active_loc, 1);
    wr(1, 0, 8'h20); step();
    chk("R7 next grant loc0", active_loc, 0);
    chk("R5 active_any", active_any, 1);

    wr(0, 0, 8'h9D); step();
    rd(0, 0, 8'hA0, "R10 undefined bits");
    chk("R10 owner kept", active_loc, 0);
    wr(0, 0, 8'h20);
    chk("R9 event to none", loc_change, 1);
    step();
    chk("R7 no owner left", active_any, 0);
    chk("R9 event cleared", loc_change, 0);
    rd(0, 0, 8'h80, "R5 no active bit");
    rd(2, 0, 8'h80, "R7 request cleared");

    step(); step();
    chk("R11 all reads answered", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule